// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches a port of pins, by default eight, and raises one interrupt request for the whole port. Each pin has its own trigger mode: rising edge, falling edge, any change, steady high or steady low. When a pin's selected event occurs, the block sets a sticky flag for that pin. The flag is set whether or not the pin's interrupt is enabled. A build-time option can block flags on pins that are driven as outputs.

The port request is high while any pin has both its flag and its enable set. A flag that was set while the pin was masked therefore stays pending and raises the request as soon as the pin is enabled. All pins share the one request, so software reads the flag vector to find the pin that caused it. Software then clears flags by writing ones to their bits.

Pin values arrive already synchronized. Configuration uses three write strobes: a full mode word, a full enable word and a clear mask.

Top module: `gpio_port_irq`

## Requirements
- R1: While reset is held and after its release, every flag is 0, every enable is 0, every pin is in rising mode (code 0) and the port request is 0.
- R2: In mode code 0 (rising), a pin's flag is set on the clock where the current sample is 1 and the sample from the previous clock was 0.
- R3: In mode code 1 (falling), a pin's flag is set on the clock where the current sample is 0 and the previous sample was 1.
- R4: In mode code 2 (any change), a pin's flag is set on every clock where the current sample differs from the previous one.
- R5: Mode code 3 sets the flag on every clock the sample is 1, and code 4 on every clock it is 0. Codes 5, 6 and 7 never set a flag.
- R6: A pin's flag is set by its event whether its enable bit is 0 or 1.
- R7: The port request equals the OR over pins of (flag AND enable). A pin whose enable is 0 never drives the request.
- R8: A flag stays set until a clear write with a 1 in that bit position. Bits written as 0 leave their flags unchanged. If an event occurs on the same clock as the clear, the flag stays set.
- R9: With DIR_GATE=1, a pin whose direction bit is 1 (output) never gets a flag. With DIR_GATE=0, flags are set regardless of direction.
- R10: When a pin with a pending flag is enabled, the port request is high in the cycle after the enable write.
- R11: The first sample after reset is not compared against anything, so no edge is reported on that clock.
- R12: A mode or enable write takes effect on the clock after the write. Event detection on the write clock uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | N | Synchronized pin values |
| dir_i | input | N | Pin direction, 1 = output |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | N*3 | Mode codes, pin i in bits [3i+2:3i] |
| en_we | input | 1 | Write strobe for the enable word |
| en_wdata | input | N | Per-pin interrupt enable |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_wdata | input | N | Write-one-to-clear mask |
| flags_o | output | N | Sticky per-pin flags |
| irq_o | output | 1 | Port-level interrupt request |

## Verification
The bench builds two instances with the default eight pins and feeds both the same stimulus. One has DIR_GATE=1 and the other DIR_GATE=0. Output-direction pins can therefore be checked both ways in the same cycles: the gated instance must never flag them, and the ungated one flags them as usual. Eight pins are enough to run all five modes and the reserved codes on different pins at once. They also allow mixed enable and clear patterns in which masked and unmasked flags coexist.

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int N        = 8,
  parameter int MW       = 3,
  parameter bit DIR_GATE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pin_i,
  input  logic [N-1:0]    dir_i,
  input  logic            mode_we,
  input  logic [N*MW-1:0] mode_wdata,
  input  logic            en_we,
  input  logic [N-1:0]    en_wdata,
  input  logic            clr_we,
  input  logic [N-1:0]    clr_wdata,
  output logic [N-1:0]    flags_o,
  output logic            irq_o
);
  localparam logic [MW-1:0] M_RISE = MW'(0);
  localparam logic [MW-1:0] M_FALL = MW'(1);
  localparam logic [MW-1:0] M_ANY  = MW'(2);
  localparam logic [MW-1:0] M_HIGH = MW'(3);
  localparam logic [MW-1:0] M_LOW  = MW'(4);

  logic [N-1:0][MW-1:0] mode_q;
  logic [N-1:0]         en_q, flag_q, prev_q, hit, allow;
  logic                 seen_q;

  assign allow = DIR_GATE ? ~dir_i : {N{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      unique case (mode_q[i])
        M_RISE:  hit[i] = seen_q &  pin_i[i] & ~prev_q[i];
        M_FALL:  hit[i] = seen_q & ~pin_i[i] &  prev_q[i];
        M_ANY:   hit[i] = seen_q & (pin_i[i] ^ prev_q[i]);
        M_HIGH:  hit[i] = pin_i[i];
        M_LOW:   hit[i] = ~pin_i[i];
        default: hit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      flag_q <= '0;
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      seen_q <= 1'b1;
      flag_q <= (flag_q & ~(clr_we ? clr_wdata : '0)) | (hit & allow);
      if (mode_we) mode_q <= mode_wdata;
      if (en_we)   en_q   <= en_wdata;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_q);
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk #(
  parameter int N        = 8,
  parameter int MW       = 3,
  parameter bit DIR_GATE = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         dir_i,
  input logic                 en_we,
  input logic [N-1:0]         en_wdata,
  input logic                 clr_we,
  input logic [N-1:0]         clr_wdata,
  input logic [N-1:0]         flags_o,
  input logic                 irq_o,
  input logic [N-1:0][MW-1:0] mode_q
);
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_o != '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_o[i]) |-> $past(clr_we && clr_wdata[i]));

    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[i]) |-> ($past(mode_q[i]) <= MW'(4)));

    a_r10_unmask: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_we && en_wdata[i]) && flags_o[i]) |-> irq_o);

    if (DIR_GATE) begin : g_gate
      a_r9_dir_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[i]) |-> !$past(dir_i[i]));
    end
  end
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.N(N), .MW(MW), .DIR_GATE(DIR_GATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .en_we(en_we), .en_wdata(en_wdata),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .flags_o(flags_o), .irq_o(irq_o),
  .mode_q(mode_q)
);

// File: tb/sim_gpio_port_irq.sv
module sim_gpio_port_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  pin = '0, dir = '0, en_wdata = '0, clr_wdata = '0;
  logic [23:0] mode_wdata = '0;
  logic mode_we = 1'b0, en_we = 1'b0, clr_we = 1'b0;
  logic [7:0] fl0, fl1;
  logic irq0, irq1;

  int tests = 0, fails = 0;
  string cur = "R1";
  logic [2:0] sh_mode [8];

  always #4 clk = ~clk;

  gpio_port_irq #(.N(8), .MW(3), .DIR_GATE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .en_we(en_we), .en_wdata(en_wdata), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .flags_o(fl0), .irq_o(irq0));

  gpio_port_irq #(.N(8), .MW(3), .DIR_GATE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .en_we(en_we), .en_wdata(en_wdata), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .flags_o(fl1), .irq_o(irq1));

  // reference model
  int m_mode [8];
  bit m_en [8], m_prev [8], m_f0 [8], m_f1 [8];
  bit m_seen;

  function automatic bit ev(int md, bit cur_v, bit prv, bit seen);
    case (md)
      0: return seen && cur_v && !prv;
      1: return seen && !cur_v && prv;
      2: return seen && (cur_v != prv);
      3: return cur_v;
      4: return !cur_v;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_mode[i] = 0; m_en[i] = 0; m_prev[i] = 0; m_f0[i] = 0; m_f1[i] = 0;
      end
      m_seen = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit e, c;
        e = ev(m_mode[i], pin[i], m_prev[i], m_seen);
        c = clr_we && clr_wdata[i];
        m_f0[i] = (m_f0[i] && !c) || (e && !dir[i]);
        m_f1[i] = (m_f1[i] && !c) || e;
        if (mode_we) m_mode[i] = int'(mode_wdata[i*3 +: 3]);
        if (en_we) m_en[i] = en_wdata[i];
        m_prev[i] = pin[i];
      end
      m_seen = 1;
    end
    #2 compare();
  end

  task automatic compare();
    logic [7:0] e0, e1;
    bit q0, q1;
    q0 = 0; q1 = 0;
    for (int i = 0; i < 8; i++) begin
      e0[i] = m_f0[i]; e1[i] = m_f1[i];
      q0 |= m_f0[i] && m_en[i];
      q1 |= m_f1[i] && m_en[i];
    end
    check({fl0, irq0}, {e0, q0}, "gated");
    check({fl1, irq1}, {e1, q1}, "ungated");
  endtask

  task automatic check(logic [8:0] act, logic [8:0] exp, string who);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: flags/irq actual=%b_%b expected=%b_%b",
               cur, who, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_modes();
    for (int i = 0; i < 8; i++) mode_wdata[i*3 +: 3] = sh_mode[i];
    mode_we = 1'b1; tick(); mode_we = 1'b0;
  endtask

  task automatic all_modes(logic [2:0] c);
    for (int i = 0; i < 8; i++) sh_mode[i] = c;
    put_modes();
  endtask

  task automatic set_en(logic [7:0] v);
    en_wdata = v; en_we = 1'b1; tick(); en_we = 1'b0;
  endtask

  task automatic clear(logic [7:0] v);
    clr_wdata = v; clr_we = 1'b1; tick(); clr_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    for (int i = 0; i < 8; i++) sh_mode[i] = 3'd0;
    pin = 8'hFF;
    tick(3);
    cur = "R1"; tests++;
    if (fl0 !== 8'h00 || irq0 !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual=%h/%b expected=00/0", fl0, irq0);
    end
    rst_n = 1'b1;
    cur = "R11"; tick(3);                 // pins held high: no edge after reset
    cur = "R2"; pin = 8'h00; tick(); pin = 8'h0F; tick(2);
    tests++;
    if (fl1 !== 8'h0F) begin
      fails++;
      $display("FAIL R2: actual=%h expected=0f", fl1);
    end
    cur = "R6"; tick();                   // flags set with all enables 0
    cur = "R8"; clear(8'h03); tick(); clear(8'hFF); tick();
    cur = "R12"; sh_mode[0] = 3'd1; mode_wdata = 24'd0; mode_wdata[2:0] = 3'd1;
    mode_we = 1'b1; pin = 8'h0E; tick(); mode_we = 1'b0; tick(); pin = 8'h0F; tick(); pin = 8'h0E; tick();
    clear(8'hFF);
    cur = "R3"; all_modes(3'd1); pin = 8'hFF; tick(); pin = 8'h3C; tick(2); clear(8'hFF);
    cur = "R4"; all_modes(3'd2); pin = 8'hA5; tick(); pin = 8'h5A; tick(); clear(8'hFF); tick();
    pin = 8'h5B; tick(); clear(8'hFF);
    cur = "R5";
    for (int i = 0; i < 8; i++) sh_mode[i] = 3'(i < 3 ? 3 : (i < 5 ? 4 : i));
    put_modes(); pin = 8'hE5; tick(3);
    cur = "R8"; clear(8'hFF); tick(); pin = 8'h00; clear(8'h1F); tick(2);
    cur = "R7"; all_modes(3'd2); clear(8'hFF); pin = 8'hFF; tick();
    set_en(8'h11); tick(); clear(8'h01); tick(); clear(8'h10); tick();
    cur = "R10"; pin = 8'h00; tick(); set_en(8'h00); tick(2); set_en(8'h80); tick(2);
    set_en(8'h00); clear(8'hFF);
    cur = "R9"; dir = 8'hF0; pin = 8'hFF; tick(); pin = 8'h00; tick(); set_en(8'hF0); tick(2);
    clear(8'hFF); dir = 8'h00;
    cur = "R7"; lf = 8'h5B;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      pin = lf;
      dir = {lf[0], lf[3], 6'b0};
      if (k % 7 == 0) begin
        for (int i = 0; i < 8; i++) sh_mode[i] = 3'((i + k) % 8);
        put_modes();
      end
      if (k % 5 == 0) set_en(lf ^ 8'h3C);
      if (k % 6 == 0) clear(lf);
      tick();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule